// File: doc/BRIEF.md
# Triggered Bus Trace Buffer

This block sits beside a parallel 8-bit processor bus and records one entry per completed bus cycle into a circular store of 512 entries. Each entry holds the 16-bit address, the 8-bit data byte and a flag that tells a read from a write. A supervisor loads a 16-bit stop address through two byte registers and then arms the block. While it is armed, every bus cycle is stored at the write pointer and the pointer then moves on. The store wraps silently.

When an armed bus cycle carries the stop address, whether it is a read or a write, that cycle is still stored. Capture then halts and the pointer is frozen on the entry it just wrote. The store now holds the stop cycle and the 511 cycles that led up to it. The supervisor writes a 9-bit index and reads entries back in time order: index 0 is the oldest entry and index 511 is the stop cycle. Status outputs report the armed flag, the triggered flag and the frozen pointer. Writing the control register again clears the triggered flag and resumes capture.

Top module: `bus_trace_buffer`

## Requirements
- R1: After reset, armed and triggered are both 0 and the pointer is 0. Bus cycles seen while disarmed neither store an entry nor move the pointer.
- R2: The supervisor writes registers with regWrite and a 3-bit regSel. Select 0 loads the low byte of the stop address. Select 1 loads the high byte. Select 2 loads index bits 7..0. Select 3 loads index bit 8 from data bit 0. Select 4 is control: data bit 0 = 1 arms the block and clears triggered, and data bit 0 = 0 disarms it.
- R3: While armed, each cycle with busValid high stores {busAddr, busData, busRead} at the pointer. If the address does not match, the pointer then advances by one modulo 512.
- R4: An armed bus cycle whose full 16-bit address equals the stop address is stored. On the next edge, armed drops to 0 and triggered rises to 1, and the pointer stays on that entry. A read and a write both match.
- R5: Once triggered and disarmed, further bus cycles (including ones at the stop address) change neither the pointer nor any stored entry.
- R6: The read-back outputs show the entry at store location (pointer + 1 + index) mod 512. They are valid on the second clock edge after the index or the pointer changes. Index 511 therefore returns the trigger entry, and indices 0..510 return the 511 preceding cycles, oldest first.
- R7: A stop-address match is judged against the stop address held before the edge. A register write in the same cycle affects only later bus cycles.
- R8: When a control write with bit 0 = 1 coincides with a matching bus cycle, the entry is stored and the pointer stays. The block ends armed with triggered clear. The next armed cycle overwrites the trigger location.
- R9: armed and triggered are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | One-cycle strobe per completed bus cycle |
| busAddr | input | 16 | Bus address |
| busData | input | 8 | Bus data |
| busRead | input | 1 | 1 = read cycle, 0 = write cycle |
| regWrite | input | 1 | Supervisor register write strobe |
| regSel | input | 3 | Register select |
| regWdata | input | 8 | Register write data |
| statArmed | output | 1 | Capture running |
| statTriggered | output | 1 | Stop address was seen |
| statPtr | output | 9 | Write pointer, frozen on the trigger entry |
| rdAddr | output | 16 | Address field of the indexed entry |
| rdData | output | 8 | Data field of the indexed entry |
| rdRead | output | 1 | Read flag of the indexed entry |

## Verification
Supervisor writes and bus capture can fall in the same clock cycle. The bench drives that overlap in two ways. First, it rewrites a stop-address byte during a bus cycle that carries the old stop address, and expects the old value to trigger. Second, it issues an arm write during a matching bus cycle, and expects armed set, triggered clear and the pointer held. A bench model updates with the same priorities, and full 512-entry read-back sweeps are compared against that model after each overlap.

// File: rtl/trace_pkg.sv
package trace_pkg;
  localparam int BUS_ADDR_W = 16;
  localparam int BUS_DATA_W = 8;
  localparam int PTR_W      = 9;
  localparam int DEPTH      = 1 << PTR_W;
  localparam int SEL_W      = 3;
  localparam int REG_W      = 8;

  localparam logic [SEL_W-1:0] SEL_TRIG_LO = 3'd0;
  localparam logic [SEL_W-1:0] SEL_TRIG_HI = 3'd1;
  localparam logic [SEL_W-1:0] SEL_IDX_LO  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_IDX_HI  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_CTRL    = 3'd4;

  typedef struct packed {
    logic [BUS_ADDR_W-1:0] addr;
    logic [BUS_DATA_W-1:0] data;
    logic                  isRead;
  } traceEntry_t;

  typedef struct packed {
    logic             wrEn;
    logic [PTR_W-1:0] wrPtr;
    logic [PTR_W-1:0] rdPtr;
  } storeCmd_t;
endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic [BUS_ADDR_W-1:0] busAddr,
  input  logic                  regWrite,
  input  logic [SEL_W-1:0]      regSel,
  input  logic [REG_W-1:0]      regWdata,
  output storeCmd_t             cmd,
  output logic                  armed,
  output logic                  triggered,
  output logic [PTR_W-1:0]      wrPtr,
  output logic [BUS_ADDR_W-1:0] trigAddr
);
  localparam int IDX_HI_W = PTR_W - REG_W;

  logic [PTR_W-1:0] idxReg;
  logic capture, hit, armWrite;

  assign capture  = armed && busValid;
  assign hit      = capture && (busAddr == trigAddr);
  assign armWrite = regWrite && (regSel == SEL_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trigAddr <= '0;
      idxReg   <= '0;
    end else if (regWrite) begin
      case (regSel)
        SEL_TRIG_LO: trigAddr[REG_W-1:0]            <= regWdata;
        SEL_TRIG_HI: trigAddr[BUS_ADDR_W-1:REG_W]   <= regWdata[BUS_ADDR_W-REG_W-1:0];
        SEL_IDX_LO:  idxReg[REG_W-1:0]              <= regWdata;
        SEL_IDX_HI:  idxReg[PTR_W-1:REG_W]          <= regWdata[IDX_HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed     <= 1'b0;
      triggered <= 1'b0;
      wrPtr     <= '0;
    end else begin
      if (armWrite)      armed <= regWdata[0];
      else if (hit)      armed <= 1'b0;

      if (armWrite && regWdata[0]) triggered <= 1'b0;
      else if (hit)                triggered <= 1'b1;

      if (capture && !hit) wrPtr <= wrPtr + 1'b1;
    end
  end

  always_comb begin
    cmd.wrEn  = capture;
    cmd.wrPtr = wrPtr;
    cmd.rdPtr = wrPtr + PTR_W'(1) + idxReg;
  end
endmodule

// File: rtl/trace_store.sv
module trace_store
  import trace_pkg::*;
(
  input  logic        clk,
  input  storeCmd_t   cmd,
  input  traceEntry_t wrEntry,
  output traceEntry_t rdEntry
);
  traceEntry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (cmd.wrEn) mem[cmd.wrPtr] <= wrEntry;
    rdEntry <= mem[cmd.rdPtr];
  end
endmodule

// File: rtl/bus_trace_buffer.sv
module bus_trace_buffer
  import trace_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic [BUS_ADDR_W-1:0] busAddr,
  input  logic [BUS_DATA_W-1:0] busData,
  input  logic                  busRead,
  input  logic                  regWrite,
  input  logic [SEL_W-1:0]      regSel,
  input  logic [REG_W-1:0]      regWdata,
  output logic                  statArmed,
  output logic                  statTriggered,
  output logic [PTR_W-1:0]      statPtr,
  output logic [BUS_ADDR_W-1:0] rdAddr,
  output logic [BUS_DATA_W-1:0] rdData,
  output logic                  rdRead
);
  storeCmd_t             cmd;
  traceEntry_t           wrEntry, rdEntry;
  logic [BUS_ADDR_W-1:0] trigAddr;

  assign wrEntry = '{addr: busAddr, data: busData, isRead: busRead};

  trace_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr),
    .regWrite(regWrite), .regSel(regSel), .regWdata(regWdata),
    .cmd(cmd), .armed(statArmed), .triggered(statTriggered),
    .wrPtr(statPtr), .trigAddr(trigAddr)
  );

  trace_store uStore (
    .clk(clk), .cmd(cmd), .wrEntry(wrEntry), .rdEntry(rdEntry)
  );

  assign rdAddr = rdEntry.addr;
  assign rdData = rdEntry.data;
  assign rdRead = rdEntry.isRead;
endmodule

// File: rtl/bus_trace_checker.sv
module bus_trace_checker
  import trace_pkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  busValid,
  input logic [BUS_ADDR_W-1:0] busAddr,
  input logic                  regWrite,
  input logic [SEL_W-1:0]      regSel,
  input logic [REG_W-1:0]      regWdata,
  input logic                  statArmed,
  input logic                  statTriggered,
  input logic [PTR_W-1:0]      statPtr,
  input logic [BUS_ADDR_W-1:0] trigAddr
);
  logic ctrlWr;
  assign ctrlWr = regWrite && (regSel == SEL_CTRL);

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(statArmed && statTriggered));

  assert_idle_ptr_R1: assert property (@(posedge clk) disable iff (!rstN)
    !statArmed |=> $stable(statPtr));

  assert_advance_R3: assert property (@(posedge clk) disable iff (!rstN)
    (statArmed && busValid && busAddr != trigAddr) |=> statPtr == $past(statPtr) + 1'b1);

  assert_freeze_on_hit_R4: assert property (@(posedge clk) disable iff (!rstN)
    (statArmed && busValid && busAddr == trigAddr && !ctrlWr)
      |=> (statTriggered && !statArmed && $stable(statPtr)));

  assert_arm_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && regWdata[0]) |=> (statArmed && !statTriggered));

  assert_trigger_cause_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statTriggered) |-> $past(busValid && statArmed));
endmodule

bind bus_trace_buffer bus_trace_checker uChk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busAddr(busAddr),
  .regWrite(regWrite), .regSel(regSel), .regWdata(regWdata),
  .statArmed(statArmed), .statTriggered(statTriggered),
  .statPtr(statPtr), .trigAddr(trigAddr)
);

// File: tb/tb_bus_trace_buffer.sv
module tb_bus_trace_buffer;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 512;

  logic clk = 0, rstN = 0;
  logic busValid = 0, busRead = 0, regWrite = 0;
  logic [15:0] busAddr = 0;
  logic [7:0] busData = 0, regWdata = 0;
  logic [2:0] regSel = 0;
  logic statArmed, statTriggered, rdRead;
  logic [8:0] statPtr;
  logic [15:0] rdAddr;
  logic [7:0] rdData;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [24:0] mMem [DEPTH];
  int mPtr = 0;
  bit mArmed = 0, mTrig = 0;
  logic [15:0] mTrigAddr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_trace_buffer dut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one clock: drive after negedge, model update at posedge, return at next negedge
  task automatic step(bit bv, logic [15:0] a, logic [7:0] d, bit rd,
                      bit rw, logic [2:0] sel, logic [7:0] wd);
    bit cap, hit, armW;
    busValid = bv; busAddr = a; busData = d; busRead = rd;
    regWrite = rw; regSel = sel; regWdata = wd;
    @(posedge clk);
    cap  = mArmed && bv;
    hit  = cap && (a == mTrigAddr);
    armW = rw && sel == 3'd4;
    if (cap) begin
      mMem[mPtr] = {a, d, rd};
      if (!hit) mPtr = (mPtr + 1) % DEPTH;
    end
    if (armW) mArmed = wd[0]; else if (hit) mArmed = 0;
    if (armW && wd[0]) mTrig = 0; else if (hit) mTrig = 1;
    if (rw && sel == 3'd0) mTrigAddr[7:0] = wd;
    if (rw && sel == 3'd1) mTrigAddr[15:8] = wd;
    @(negedge clk);
    busValid = 0; regWrite = 0;
  endtask

  task automatic idle(); step(0, 0, 0, 0, 0, 0, 0); endtask
  task automatic wr(logic [2:0] sel, logic [7:0] v); step(0, 0, 0, 0, 1, sel, v); endtask
  task automatic bus(logic [15:0] a, logic [7:0] d, bit rd); step(1, a, d, rd, 0, 0, 0); endtask

  task automatic checkStatus(string req);
    check({req, " armed"}, int'(statArmed), int'(mArmed));
    check({req, " triggered"}, int'(statTriggered), int'(mTrig));
    check({req, " ptr"}, int'(statPtr), mPtr);
  endtask

  task automatic readIdx(int i, string req);
    logic [24:0] e;
    wr(3'd2, i[7:0]);
    wr(3'd3, {7'd0, i[8]});
    idle();
    e = mMem[(mPtr + 1 + i) % DEPTH];
    check({req, " rd"}, int'({rdAddr, rdData, rdRead}), int'(e));
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < DEPTH; i++) readIdx(i, req);
  endtask

  function automatic logic [15:0] genAddr(int i);
    logic [15:0] a = 16'((i * 37 + 5) & 16'hFFFF);
    if (a == mTrigAddr) a = a + 1;
    return a;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    checkStatus("R1 reset");
    for (int i = 0; i < 10; i++) bus(16'h1000 + 16'(i), 8'(i), 1);
    checkStatus("R1 disarmed");

    wr(3'd0, 8'hA5); wr(3'd1, 8'hC0);
    wr(3'd4, 8'h01);
    checkStatus("R2 arm");
    for (int i = 0; i < 600; i++) bus(genAddr(i), 8'(i * 3), i[0]);
    checkStatus("R3 fill");
    check("R3 ptr wrap", int'(statPtr), 600 % DEPTH);
    bus(16'hC0A5, 8'h5A, 0);
    checkStatus("R4 hit write");
    check("R4 triggered", int'(statTriggered), 1);
    sweep("R6 sweep1");
    readIdx(511, "R6 trigger entry");
    check("R6 trigger addr", int'(rdAddr), 16'hC0A5);

    for (int i = 0; i < 20; i++) bus(i == 5 ? 16'hC0A5 : 16'h2000 + 16'(i), 8'hEE, 1);
    checkStatus("R5 frozen");
    readIdx(511, "R5 frozen entry");
    readIdx(0, "R5 frozen oldest");

    wr(3'd4, 8'h01);
    checkStatus("R2 rearm");
    for (int i = 0; i < 30; i++) bus(genAddr(i + 900), 8'(i), 0);
    // R7: rewrite low byte while bus carries the old stop address
    step(1, 16'hC0A5, 8'h77, 1, 1, 3'd0, 8'h11);
    checkStatus("R7 old trigger");
    check("R7 triggered", int'(statTriggered), 1);
    sweep("R7 sweep");

    // R8: arm write coinciding with a match on new address C011
    wr(3'd4, 8'h01);
    for (int i = 0; i < 7; i++) bus(16'h3000 + 16'(i), 8'(i), 1);
    step(1, 16'hC011, 8'h42, 0, 1, 3'd4, 8'h01);
    checkStatus("R8 arm wins");
    check("R8 armed", int'(statArmed), 1);
    bus(16'h4444, 8'h44, 1);
    checkStatus("R8 overwrite");
    sweep("R8 sweep");

    // disarm, then matching bus cycles leave state
    wr(3'd4, 8'h00);
    bus(16'hC011, 8'h99, 1);
    bus(16'h5555, 8'h99, 0);
    checkStatus("R2 disarm");
    readIdx(510, "R5 disarmed entry");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule